// File: doc/BRIEF.md
# Software SMI Command Port

This block watches a byte-wide host I/O bus for writes to a two-port command window and turns them into a system-management interrupt request. A programmable base register places the window in I/O space on a 16-byte boundary. The lower port of the window is the command port. Writing a byte there latches the byte and raises the request. The port one address above it is a status byte that software may read and write freely; it never raises a request.

A small control register sits on a separate configuration interface. It offers a legacy way to raise the same request through a self-clearing bit, and a global disable bit that blocks every source. The request output is a sticky level. It stays asserted until the handler pulses a clear input, so a handler can run long after the triggering write and still see the request.

Top module: `smi_cmd_port`

## Requirements
- R1: After a synchronous active-high reset the base register, the disable bit, the command byte, the status byte and the request output are all zero.
- R2: The base register (configuration select 0) discards bits 3:0 of any value written and always reads them back as zero.
- R3: A host write to address base latches the data byte as the command byte and, when not disabled, drives `smi_o` high from the next clock edge. The byte reads back at address base, and reading it changes nothing.
- R4: A host write to address base+1 stores the status byte, which reads back at base+1. Such a write never raises the request.
- R5: A configuration write to the control register (select 1) with bit 4 set raises the request. Bit 4 is not stored and always reads back as zero.
- R6: Control bit 0 is the global disable, and its reset value is 0. While it is 1, `smi_o` is low and any trigger arriving is discarded. A request already pending before the disable is held and shows again once the bit returns to 0. A control write that sets bit 0 and bit 4 together raises nothing.
- R7: A pulse on `smi_clr` drops the pending request at the next edge. When a trigger that is allowed through arrives in the same cycle as the clear, the request stays set.
- R8: A host access to any address other than base and base+1 changes no state, and a host read there returns zero. The read data is zero whenever `io_rd` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| io_addr | input | 16 | Host I/O address |
| io_wr | input | 1 | Host write strobe, one cycle per write |
| io_rd | input | 1 | Host read enable |
| io_wdata | input | 8 | Host write data |
| io_rdata | output | 8 | Host read data (combinational) |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 1 | 0 selects the base register, 1 selects the control register |
| cfg_wdata | input | 16 | Configuration write data |
| cfg_rdata | output | 16 | Configuration read data for the selected register |
| smi_clr | input | 1 | Handler clear strobe |
| smi_o | output | 1 | Sticky SMI request |

## Verification
The properties assume that the host bus presents at most one write per cycle, with a stable address for that cycle, and that `smi_clr` is a clean single-cycle strobe. The properties on the output also assume that the configuration port is quiet in the cycle they reason about, so their guards exclude configuration writes. The stimulus drives every input once per cycle, shortly after the falling edge, so each access lasts exactly one cycle. The random phase draws its addresses from the two ports, their near neighbours and an alias that differs only in the upper bits, which keeps the near-miss decode under constant pressure.

// File: rtl/smi_port_pkg.sv
package smi_port_pkg;

    localparam int IO_AW       = 16;
    localparam int BYTE_W      = 8;
    localparam int CFG_W       = 16;
    localparam int ALIGN_LSB   = 4;
    localparam int LEGACY_BIT  = 4;
    localparam int DISABLE_BIT = 0;
    localparam int NUM_PORTS   = 2;

    // index of each port inside the window, offset from base
    typedef enum int {
        PORT_CMD    = 0,
        PORT_STATUS = 1
    } port_idx_e;

    typedef enum logic {
        CFG_BASE = 1'b0,
        CFG_CTRL = 1'b1
    } cfg_sel_e;

    typedef struct packed {
        logic       base_we;
        logic       ctrl_we;
        logic       legacy_req;
        logic       dis_next;
    } cfg_ctl_t;

    function automatic logic [IO_AW-1:0] align_base(input logic [IO_AW-1:0] raw);
        logic [IO_AW-1:0] mask;
        mask = {IO_AW{1'b1}} << ALIGN_LSB;
        return raw & mask;
    endfunction

endpackage

// File: rtl/smi_port_decode.sv
module smi_port_decode
    import smi_port_pkg::*;
#(
    parameter int AW     = IO_AW,
    parameter int NPORTS = NUM_PORTS
) (
    input  logic [AW-1:0]     addr,
    input  logic [AW-1:0]     base,
    output logic [NPORTS-1:0] hit_vec
);

    // one comparator per port of the window
    for (genvar p = 0; p < NPORTS; p++) begin : g_port
        localparam logic [AW-1:0] OFFSET = AW'(p);
        assign hit_vec[p] = (addr == (base + OFFSET));
    end

endmodule

// File: rtl/smi_cfg_regs.sv
module smi_cfg_regs
    import smi_port_pkg::*;
#(
    parameter int AW      = IO_AW,
    parameter int CW      = CFG_W,
    parameter int LEG_BIT = LEGACY_BIT,
    parameter int DIS_BIT = DISABLE_BIT
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          cfg_we,
    input  logic          cfg_sel,
    input  logic [CW-1:0] cfg_wdata,
    output logic [AW-1:0] base_q,
    output logic          dis_q,
    output cfg_ctl_t      ctl,
    output logic [CW-1:0] cfg_rdata
);

    always_comb begin
        ctl.base_we    = cfg_we && (cfg_sel == CFG_BASE);
        ctl.ctrl_we    = cfg_we && (cfg_sel == CFG_CTRL);
        ctl.legacy_req = ctl.ctrl_we && cfg_wdata[LEG_BIT];
        ctl.dis_next   = ctl.ctrl_we ? cfg_wdata[DIS_BIT] : dis_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            base_q <= '0;
            dis_q  <= 1'b0;
        end else begin
            if (ctl.base_we) begin
                base_q <= align_base(cfg_wdata[AW-1:0]);
            end
            dis_q <= ctl.dis_next;
        end
    end

    always_comb begin
        cfg_rdata = '0;
        if (cfg_sel == CFG_BASE) begin
            cfg_rdata[AW-1:0] = base_q;
        end else begin
            cfg_rdata[DIS_BIT] = dis_q;
        end
    end

endmodule

// File: rtl/smi_data_regs.sv
module smi_data_regs
    import smi_port_pkg::*;
#(
    parameter int DW     = BYTE_W,
    parameter int NPORTS = NUM_PORTS
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr,
    input  logic              rd,
    input  logic [NPORTS-1:0] hit_vec,
    input  logic [DW-1:0]     wdata,
    output logic [DW-1:0]     rdata
);

    logic [DW-1:0] port_q [NPORTS];

    // each port of the window holds one byte
    for (genvar p = 0; p < NPORTS; p++) begin : g_byte
        always_ff @(posedge clk) begin
            if (rst) begin
                port_q[p] <= '0;
            end else if (wr && hit_vec[p]) begin
                port_q[p] <= wdata;
            end
        end
    end

    always_comb begin
        rdata = '0;
        if (rd) begin
            for (int p = 0; p < NPORTS; p++) begin
                if (hit_vec[p]) begin
                    rdata = port_q[p];
                end
            end
        end
    end

endmodule

// File: rtl/smi_req_ctrl.sv
module smi_req_ctrl (
    input  logic clk,
    input  logic rst,
    input  logic trig_cmd,
    input  logic trig_legacy,
    input  logic dis_next,
    input  logic dis_q,
    input  logic clr,
    output logic pend_q,
    output logic smi_o
);

    logic trig_ok;

    assign trig_ok = (trig_cmd || trig_legacy) && !dis_next;

    // set takes priority over clear
    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q <= 1'b0;
        end else if (trig_ok) begin
            pend_q <= 1'b1;
        end else if (clr) begin
            pend_q <= 1'b0;
        end
    end

    assign smi_o = pend_q && !dis_q;

endmodule

// File: rtl/smi_cmd_port.sv
module smi_cmd_port
    import smi_port_pkg::*;
#(
    parameter int AW      = IO_AW,
    parameter int DW      = BYTE_W,
    parameter int CW      = CFG_W,
    parameter int LEG_BIT = LEGACY_BIT,
    parameter int DIS_BIT = DISABLE_BIT
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [AW-1:0] io_addr,
    input  logic          io_wr,
    input  logic          io_rd,
    input  logic [DW-1:0] io_wdata,
    output logic [DW-1:0] io_rdata,
    input  logic          cfg_we,
    input  logic          cfg_sel,
    input  logic [CW-1:0] cfg_wdata,
    output logic [CW-1:0] cfg_rdata,
    input  logic          smi_clr,
    output logic          smi_o
);

    localparam int NPORTS = NUM_PORTS;

    logic [AW-1:0]     base_q;
    logic              dis_q;
    cfg_ctl_t          ctl;
    logic [NPORTS-1:0] hit_vec;
    logic              cmd_hit_wr;
    logic              pend_q;

    smi_cfg_regs #(
        .AW(AW), .CW(CW), .LEG_BIT(LEG_BIT), .DIS_BIT(DIS_BIT)
    ) cfg_i (
        .clk(clk), .rst(rst),
        .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
        .base_q(base_q), .dis_q(dis_q), .ctl(ctl), .cfg_rdata(cfg_rdata)
    );

    smi_port_decode #(.AW(AW), .NPORTS(NPORTS)) dec_i (
        .addr(io_addr), .base(base_q), .hit_vec(hit_vec)
    );

    smi_data_regs #(.DW(DW), .NPORTS(NPORTS)) data_i (
        .clk(clk), .rst(rst),
        .wr(io_wr), .rd(io_rd), .hit_vec(hit_vec),
        .wdata(io_wdata), .rdata(io_rdata)
    );

    assign cmd_hit_wr = io_wr && hit_vec[PORT_CMD];

    smi_req_ctrl req_i (
        .clk(clk), .rst(rst),
        .trig_cmd(cmd_hit_wr), .trig_legacy(ctl.legacy_req),
        .dis_next(ctl.dis_next), .dis_q(dis_q),
        .clr(smi_clr), .pend_q(pend_q), .smi_o(smi_o)
    );

endmodule

// File: rtl/smi_cmd_port_chk.sv
module smi_cmd_port_chk #(
    parameter int AW      = 16,
    parameter int CW      = 16,
    parameter int LEG_BIT = 4,
    parameter int DIS_BIT = 0
) (
    input logic          clk,
    input logic          rst,
    input logic [AW-1:0] io_addr,
    input logic          io_wr,
    input logic          cfg_we,
    input logic          cfg_sel,
    input logic [CW-1:0] cfg_wdata,
    input logic [CW-1:0] cfg_rdata,
    input logic          smi_clr,
    input logic          smi_o,
    input logic [AW-1:0] base_q,
    input logic          dis_q,
    input logic          pend_q
);

    logic at_cmd, at_stat;
    assign at_cmd  = (io_addr == base_q);
    assign at_stat = (io_addr == AW'(base_q + AW'(1)));

    // R2
    base_low_zero_chk: assert property (@(posedge clk) disable iff (rst)
        !cfg_sel |-> cfg_rdata[3:0] == 4'h0);

    // R3
    cmd_write_raises_chk: assert property (@(posedge clk) disable iff (rst)
        (io_wr && at_cmd && !dis_q && !cfg_we) |=> smi_o);

    // R4
    no_spurious_pend_chk: assert property (@(posedge clk) disable iff (rst)
        (!pend_q && !(io_wr && at_cmd) && !(cfg_we && cfg_sel && cfg_wdata[LEG_BIT]))
        |=> !pend_q);

    // R5
    legacy_raises_chk: assert property (@(posedge clk) disable iff (rst)
        (cfg_we && cfg_sel && cfg_wdata[LEG_BIT] && !cfg_wdata[DIS_BIT]) |=> smi_o);

    // R6
    disable_masks_chk: assert property (@(posedge clk) disable iff (rst)
        dis_q |-> !smi_o);

    // R7
    clear_drops_chk: assert property (@(posedge clk) disable iff (rst)
        (smi_clr && !io_wr && !cfg_we) |=> !smi_o);

    // R8
    miss_no_change_chk: assert property (@(posedge clk) disable iff (rst)
        (io_wr && !at_cmd && !at_stat && !cfg_we && !smi_clr)
        |=> ($stable(pend_q) && $stable(dis_q) && $stable(base_q)));

endmodule

bind smi_cmd_port smi_cmd_port_chk #(
    .AW(AW), .CW(CW), .LEG_BIT(LEG_BIT), .DIS_BIT(DIS_BIT)
) chk_i (
    .clk(clk), .rst(rst), .io_addr(io_addr), .io_wr(io_wr),
    .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .smi_clr(smi_clr), .smi_o(smi_o),
    .base_q(base_q), .dis_q(dis_q), .pend_q(pend_q)
);

// File: tb/smi_cmd_port_tb.sv
module smi_cmd_port_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 20000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] io_addr = '0;
    logic        io_wr = 1'b0, io_rd = 1'b0;
    logic [7:0]  io_wdata = '0;
    logic [7:0]  io_rdata;
    logic        cfg_we = 1'b0, cfg_sel = 1'b0;
    logic [15:0] cfg_wdata = '0;
    logic [15:0] cfg_rdata;
    logic        smi_clr = 1'b0;
    logic        smi_o;

    int tests = 0, fails = 0;
    string cur_req = "R1";
    bit started = 0;

    smi_cmd_port dut_i (
        .clk(clk), .rst(rst), .io_addr(io_addr), .io_wr(io_wr), .io_rd(io_rd),
        .io_wdata(io_wdata), .io_rdata(io_rdata), .cfg_we(cfg_we),
        .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .smi_clr(smi_clr), .smi_o(smi_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // behavioural reference state
    logic [15:0] m_base;
    logic        m_dis, m_pend;
    logic [7:0]  m_cmd, m_stat;
    logic        m_dn, m_trig;

    always @(posedge clk) begin
        started <= 1;
        if (rst) begin
            m_base <= 0; m_dis <= 0; m_pend <= 0; m_cmd <= 0; m_stat <= 0;
        end else begin
            m_dn   = (cfg_we && cfg_sel) ? cfg_wdata[0] : m_dis;
            m_trig = (io_wr && io_addr == m_base) || (cfg_we && cfg_sel && cfg_wdata[4]);
            if (io_wr && io_addr == m_base) m_cmd <= io_wdata;
            if (io_wr && io_addr == 16'(m_base + 16'd1)) m_stat <= io_wdata;
            if (cfg_we && !cfg_sel) m_base <= cfg_wdata & 16'hFFF0;
            m_dis <= m_dn;
            if (m_trig && !m_dn) m_pend <= 1;
            else if (smi_clr) m_pend <= 0;
        end
    end

    function automatic logic [7:0] exp_io();
        if (!io_rd) return 8'h00;
        if (io_addr == m_base) return m_cmd;
        if (io_addr == 16'(m_base + 16'd1)) return m_stat;
        return 8'h00;
    endfunction

    task automatic check(input string req, input string what,
                         input logic [15:0] act, input logic [15:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // compare against the model on every clock
    always @(negedge clk) begin
        if (started) begin
            check(cur_req, "model smi_o", 16'(smi_o), 16'(m_pend & ~m_dis));
            check(cur_req, "model io_rdata", 16'(io_rdata), 16'(exp_io()));
            check(cur_req, "model cfg_rdata", cfg_rdata,
                  cfg_sel ? {15'd0, m_dis} : m_base);
        end
    end

    task automatic drive(input logic wr, input logic rd, input logic [15:0] a,
                         input logic [7:0] d, input logic cwe, input logic csel,
                         input logic [15:0] cd, input logic clr);
        #1;
        io_wr = wr; io_rd = rd; io_addr = a; io_wdata = d;
        cfg_we = cwe; cfg_sel = csel; cfg_wdata = cd; smi_clr = clr;
        @(negedge clk);
    endtask

    task automatic idle();            drive(0,0,16'h0,8'h0,0,0,16'h0,0); endtask
    task automatic iow(input logic [15:0] a, input logic [7:0] d);
        drive(1,0,a,d,0,0,16'h0,0); idle();
    endtask
    task automatic cfgw(input logic s, input logic [15:0] d);
        drive(0,0,16'h0,8'h0,1,s,d,0); idle();
    endtask
    task automatic clr();             drive(0,0,16'h0,8'h0,0,0,16'h0,1); idle(); endtask
    task automatic ior(input string req, input logic [15:0] a, input logic [7:0] e);
        drive(0,1,a,8'h0,0,0,16'h0,0);
        check(req, "io read", 16'(io_rdata), 16'(e));
    endtask
    task automatic cfgr(input string req, input logic s, input logic [15:0] e);
        drive(0,0,16'h0,8'h0,0,s,16'h0,0);
        check(req, "cfg read", cfg_rdata, e);
    endtask

    initial begin : watchdog
        repeat (WATCHDOG) @(posedge clk);
        fails++;
        tests++;
        $display("FAIL watchdog: actual expired expected finish");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        #1 rst = 0;
        @(negedge clk);
        cur_req = "R1";
        check("R1", "smi_o after reset", 16'(smi_o), 16'h0);
        cfgr("R1", 0, 16'h0000);
        cfgr("R1", 1, 16'h0000);
        ior("R1", 16'h0000, 8'h00);
        ior("R1", 16'h0001, 8'h00);

        cur_req = "R2";
        cfgw(0, 16'h00B3);
        cfgr("R2", 0, 16'h00B0);

        cur_req = "R3";
        drive(1,0,16'h00B0,8'h5A,0,0,16'h0,0);
        check("R3", "smi after cmd write", 16'(smi_o), 16'h1);
        idle();
        ior("R3", 16'h00B0, 8'h5A);
        ior("R3", 16'h00B0, 8'h5A);
        check("R3", "smi held after read", 16'(smi_o), 16'h1);

        cur_req = "R7";
        drive(0,0,16'h0,8'h0,0,0,16'h0,1);
        check("R7", "smi after clear", 16'(smi_o), 16'h0);
        idle();

        cur_req = "R4";
        iow(16'h00B1, 8'h3C);
        check("R4", "no smi on status write", 16'(smi_o), 16'h0);
        ior("R4", 16'h00B1, 8'h3C);

        cur_req = "R8";
        iow(16'h00B2, 8'hFF);
        iow(16'h00AF, 8'h11);
        iow(16'h10B0, 8'h22);
        check("R8", "no smi on miss", 16'(smi_o), 16'h0);
        ior("R8", 16'h00B0, 8'h5A);
        ior("R8", 16'h00B1, 8'h3C);
        ior("R8", 16'h00B2, 8'h00);
        ior("R8", 16'h10B0, 8'h00);

        cur_req = "R5";
        drive(0,0,16'h0,8'h0,1,1,16'h0010,0);
        check("R5", "smi after legacy bit", 16'(smi_o), 16'h1);
        idle();
        cfgr("R5", 1, 16'h0000);
        clr();

        cur_req = "R6";
        cfgw(1, 16'h0001);
        cfgr("R6", 1, 16'h0001);
        iow(16'h00B0, 8'h77);
        check("R6", "no smi while disabled", 16'(smi_o), 16'h0);
        ior("R6", 16'h00B0, 8'h77);
        cfgw(1, 16'h0000);
        check("R6", "dropped trigger stays dropped", 16'(smi_o), 16'h0);
        iow(16'h00B0, 8'h78);
        cfgw(1, 16'h0001);
        check("R6", "pending masked", 16'(smi_o), 16'h0);
        cfgw(1, 16'h0000);
        check("R6", "pending shows again", 16'(smi_o), 16'h1);
        clr();
        cfgw(1, 16'h0011);
        check("R6", "legacy with disable", 16'(smi_o), 16'h0);
        cfgw(1, 16'h0000);
        check("R6", "legacy with disable dropped", 16'(smi_o), 16'h0);

        cur_req = "R7";
        drive(1,0,16'h00B0,8'h99,0,0,16'h0,1);
        check("R7", "set wins over clear", 16'(smi_o), 16'h1);
        clr();

        cur_req = "R8";
        for (int i = 0; i < 600; i++) begin
            logic [15:0] a;
            int pick;
            pick = $urandom_range(0, 5);
            case (pick)
                0: a = 16'h00B0; 1: a = 16'h00B1; 2: a = 16'h00B2;
                3: a = 16'h00AF; 4: a = 16'h10B0; default: a = 16'h00BF;
            endcase
            drive($urandom_range(0,2) == 0, $urandom_range(0,1) == 1, a,
                  8'($urandom), $urandom_range(0,9) == 0, 1'($urandom),
                  16'($urandom) & 16'h00F1 | 16'h00B0 & {16{1'b0}},
                  $urandom_range(0,4) == 0);
            if ((i % 50) == 0) cfgw(0, 16'h00B0);
        end
        idle();

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule